// File: doc/BRIEF.md
# Single-Accumulator 16-bit Processor Core

This block is a small 16-bit processor built around one accumulator. It runs one 16-bit instruction per clock cycle from an internal instruction store. It works on an internal data store of 16-bit words, and it reaches external devices through a strobed byte-addressed port. Each instruction carries an 8-bit field. That field is either a sign-extended constant or a direct data address. Indirect accesses add this field to an address register. The address register is reloaded after every instruction, so only the next instruction sees the new value.

Conditional branches and jump-and-link do not use the current accumulator. They use the accumulator value as it stood before the previous instruction, which is the result of the instruction two places back. Programs must be scheduled around this delay. The instruction store has a write port so that a host can load code while the core is held in reset. Execution starts at word 1, and word 0 is never run.

Top module: `acc16_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 1 and clears the accumulator, the address register, the delayed accumulator copy and `illegal_o`. While `rst` is high, `io_wr` and `io_rd` stay low. The word at instruction address 0 is never executed.
- R2: Bit 8 of an instruction selects the operand. When bit 8 is 1, the operand is bits [7:0] sign-extended to 16 bits. When bit 8 is 0, the operand is the data word at address bits [7:0].
- R3: The ALU opcodes sit in bits [15:9]: 0x00 no-op, 0x04 add, 0x06 subtract, 0x08 logical shift right by one, 0x10 load, 0x11 and, 0x12 or, 0x13 xor. Each writes its result to the accumulator. Addition and subtraction wrap modulo 2^16.
- R4: Opcode 0x14 (load-high) sets the accumulator to the operand's low byte in bits [15:8] and keeps the accumulator's own low byte in bits [7:0].
- R5: Opcode 0x18 writes the accumulator to the data word at address bits [7:0].
- R6: Opcode 0x1C raises `io_wr` for that one cycle, with `io_addr` = bits [7:0] and `io_wdata` = accumulator. Opcode 0x1E raises `io_rd` with the same address, and the accumulator takes `io_rdata` at the end of the cycle.
- R7: After every instruction, the address register takes the data word at bits [7:0]. If the same instruction writes that word, the new value is taken. Opcode 0x30 loads the accumulator from data address (address register + bits [7:0]). Opcode 0x38 stores the accumulator there. Opcode 0x28 leaves the accumulator unchanged.
- R8: Branches decode bits [15:8]: 0x48 always, 0x49 if zero, 0x4A if nonzero, 0x4B if bit 15 is clear, 0x4C if bit 15 is set. The target is PC + sign-extended bits [7:0]. The condition tests the accumulator value from before the previous instruction.
- R9: Opcode 0x20 writes PC+1 to the data word at bits [7:0]. It then continues at the accumulator value from before the previous instruction.
- R10: Any other encoding acts as a no-op and sets `illegal_o`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 10 | Instruction store write address |
| imem_wdata | input | 16 | Instruction store write data |
| io_addr | output | 8 | Device port address |
| io_wdata | output | 16 | Device port write data |
| io_wr | output | 1 | Device write strobe, one cycle |
| io_rd | output | 1 | Device read strobe, one cycle |
| io_rdata | input | 16 | Device read data |
| illegal_o | output | 1 | Sticky undefined-instruction flag |

## Verification
A direct store and the address-register reload can hit the same data word in the same cycle. The reload must then take the value being written, not the stale word. The bench provokes this by storing to word 20 and following it at once with an indirect load offset by 5. The accumulator can only return the prepared value at word 8 if the address register forwarded the stored 3. Jump-and-link writes its link word in the same way, and the link word is read back after the jump. Each case is judged by the value the program sends to the device port.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

   localparam int unsigned WORD_W = 16;

   localparam logic [6:0] OPC_NOP  = 7'h00;
   localparam logic [6:0] OPC_ADD  = 7'h04;
   localparam logic [6:0] OPC_SUB  = 7'h06;
   localparam logic [6:0] OPC_SHR  = 7'h08;
   localparam logic [6:0] OPC_LD   = 7'h10;
   localparam logic [6:0] OPC_AND  = 7'h11;
   localparam logic [6:0] OPC_OR   = 7'h12;
   localparam logic [6:0] OPC_XOR  = 7'h13;
   localparam logic [6:0] OPC_LDH  = 7'h14;
   localparam logic [6:0] OPC_ST   = 7'h18;
   localparam logic [6:0] OPC_OUT  = 7'h1C;
   localparam logic [6:0] OPC_IN   = 7'h1E;
   localparam logic [6:0] OPC_JAL  = 7'h20;
   localparam logic [6:0] OPC_BRA  = 7'h24;
   localparam logic [6:0] OPC_BRB  = 7'h25;
   localparam logic [6:0] OPC_BRC  = 7'h26;
   localparam logic [6:0] OPC_LDA  = 7'h28;
   localparam logic [6:0] OPC_LDX  = 7'h30;
   localparam logic [6:0] OPC_STX  = 7'h38;

   typedef enum logic [3:0] {
      ALU_NONE, ALU_ADD, ALU_SUB, ALU_SHR, ALU_LD,
      ALU_AND, ALU_OR, ALU_XOR, ALU_LDH
   } alu_op_e;

   typedef enum logic [1:0] {
      ACC_KEEP, ACC_ALU, ACC_IO, ACC_IND
   } acc_sel_e;

   typedef enum logic [2:0] {
      BR_NONE, BR_ALWAYS, BR_ZERO, BR_NZERO, BR_POS, BR_NEG, BR_LINK
   } br_kind_e;

   typedef struct packed {
      alu_op_e  alu;
      acc_sel_e sel;
      br_kind_e br;
      logic     use_imm;
      logic     st_dir;
      logic     st_ind;
      logic     io_out;
      logic     io_in;
      logic     illegal;
   } dec_t;

endpackage

// File: rtl/acc16_ram.sv
module acc16_ram #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned NRD   = 1,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [WIDTH-1:0]          wdata,
   input  logic [NRD-1:0][AW-1:0]    raddr,
   output logic [NRD-1:0][WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   if (NRD < 1) begin : g_bad_nrd
      $error("acc16_ram needs at least one read port");
   end

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
   end

endmodule

// File: rtl/acc16_decode.sv
module acc16_decode
   import acc16_pkg::*;
(
   input  logic [WORD_W-1:0] instr,
   output dec_t              dec
);

   logic [6:0] opc;
   assign opc = instr[15:9];

   always_comb begin
      dec         = '0;
      dec.alu     = ALU_NONE;
      dec.sel     = ACC_KEEP;
      dec.br      = BR_NONE;
      dec.use_imm = instr[8];
      case (opc)
         OPC_NOP: ;
         OPC_ADD: begin dec.alu = ALU_ADD; dec.sel = ACC_ALU; end
         OPC_SUB: begin dec.alu = ALU_SUB; dec.sel = ACC_ALU; end
         OPC_SHR: begin dec.alu = ALU_SHR; dec.sel = ACC_ALU; end
         OPC_LD:  begin dec.alu = ALU_LD;  dec.sel = ACC_ALU; end
         OPC_AND: begin dec.alu = ALU_AND; dec.sel = ACC_ALU; end
         OPC_OR:  begin dec.alu = ALU_OR;  dec.sel = ACC_ALU; end
         OPC_XOR: begin dec.alu = ALU_XOR; dec.sel = ACC_ALU; end
         OPC_LDH: begin dec.alu = ALU_LDH; dec.sel = ACC_ALU; end
         OPC_ST:  dec.st_dir = 1'b1;
         OPC_OUT: dec.io_out = 1'b1;
         OPC_IN:  begin dec.io_in = 1'b1; dec.sel = ACC_IO; end
         OPC_JAL: dec.br = BR_LINK;
         OPC_LDA: ;
         OPC_LDX: dec.sel = ACC_IND;
         OPC_STX: dec.st_ind = 1'b1;
         OPC_BRA: dec.br = instr[8] ? BR_ZERO : BR_ALWAYS;
         OPC_BRB: dec.br = instr[8] ? BR_POS  : BR_NZERO;
         OPC_BRC: begin
            if (instr[8]) dec.illegal = 1'b1;
            else          dec.br      = BR_NEG;
         end
         default: dec.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/acc16_alu.sv
module acc16_alu
   import acc16_pkg::*;
(
   input  alu_op_e           op,
   input  logic [WORD_W-1:0] acc,
   input  logic [WORD_W-1:0] opnd,
   output logic [WORD_W-1:0] res
);

   always_comb begin
      case (op)
         ALU_ADD: res = acc + opnd;
         ALU_SUB: res = acc - opnd;
         ALU_SHR: res = {1'b0, acc[WORD_W-1:1]};
         ALU_LD:  res = opnd;
         ALU_AND: res = acc & opnd;
         ALU_OR:  res = acc | opnd;
         ALU_XOR: res = acc ^ opnd;
         ALU_LDH: res = {opnd[7:0], acc[7:0]};
         default: res = acc;
      endcase
   end

endmodule

// File: rtl/acc16_branch.sv
module acc16_branch
   import acc16_pkg::*;
#(
   parameter int unsigned PC_W = 10
) (
   input  br_kind_e          br,
   input  logic [PC_W-1:0]   pc,
   input  logic [7:0]        offset,
   input  logic [WORD_W-1:0] cond_acc,
   output logic [PC_W-1:0]   next_pc
);

   logic [WORD_W-1:0] off_ext;
   logic [PC_W-1:0]   rel_tgt;
   logic              take;

   assign off_ext = {{(WORD_W-8){offset[7]}}, offset};
   assign rel_tgt = pc + off_ext[PC_W-1:0];

   always_comb begin
      case (br)
         BR_ALWAYS: take = 1'b1;
         BR_ZERO:   take = (cond_acc == '0);
         BR_NZERO:  take = (cond_acc != '0);
         BR_POS:    take = ~cond_acc[WORD_W-1];
         BR_NEG:    take = cond_acc[WORD_W-1];
         default:   take = 1'b0;
      endcase
   end

   always_comb begin
      if (br == BR_LINK)  next_pc = cond_acc[PC_W-1:0];
      else if (take)      next_pc = rel_tgt;
      else                next_pc = pc + PC_W'(1);
   end

endmodule

// File: rtl/acc16_core.sv
module acc16_core
   import acc16_pkg::*;
#(
   parameter int unsigned IMEM_DEPTH = 1024,
   parameter int unsigned DMEM_DEPTH = 1024,
   parameter int unsigned COND_LAG   = 1,
   localparam int unsigned IA_W      = $clog2(IMEM_DEPTH),
   localparam int unsigned DA_W      = $clog2(DMEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              imem_we,
   input  logic [IA_W-1:0]   imem_waddr,
   input  logic [WORD_W-1:0] imem_wdata,
   output logic [7:0]        io_addr,
   output logic [WORD_W-1:0] io_wdata,
   output logic              io_wr,
   output logic              io_rd,
   input  logic [WORD_W-1:0] io_rdata,
   output logic              illegal_o
);

   if (IA_W < 8 || IA_W > WORD_W) begin : g_bad_imem
      $error("IMEM_DEPTH must give an address width between 8 and 16");
   end
   if (DA_W < 8 || DA_W > WORD_W) begin : g_bad_dmem
      $error("DMEM_DEPTH must give an address width between 8 and 16");
   end
   if (COND_LAG < 1) begin : g_bad_lag
      $error("COND_LAG must be at least 1");
   end

   logic [IA_W-1:0]   pc_q;
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] ar_q;
   logic              illegal_q;
   logic [WORD_W-1:0] instr;
   dec_t              dec;
   logic [7:0]        fld;

   // instruction store
   logic [0:0][IA_W-1:0]   im_raddr;
   logic [0:0][WORD_W-1:0] im_rdata;
   assign im_raddr[0] = pc_q;

   acc16_ram #(.WIDTH(WORD_W), .DEPTH(IMEM_DEPTH), .NRD(1)) u_imem (
      .clk   (clk),
      .we    (imem_we),
      .waddr (imem_waddr),
      .wdata (imem_wdata),
      .raddr (im_raddr),
      .rdata (im_rdata)
   );

   assign instr = im_rdata[0];
   assign fld   = instr[7:0];

   acc16_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   // data store: port 0 direct, port 1 indirect
   logic [DA_W-1:0]          dir_addr;
   logic [DA_W-1:0]          ind_addr;
   logic [1:0][DA_W-1:0]     dm_raddr;
   logic [1:0][WORD_W-1:0]   dm_rdata;
   logic                     dm_we;
   logic [DA_W-1:0]          dm_waddr;
   logic [WORD_W-1:0]        dm_wdata;
   logic                     is_link;

   assign is_link     = (dec.br == BR_LINK);
   assign dir_addr    = DA_W'(fld);
   assign ind_addr    = ar_q[DA_W-1:0] + DA_W'(fld);
   assign dm_raddr[0] = dir_addr;
   assign dm_raddr[1] = ind_addr;
   assign dm_we       = ~rst & (dec.st_dir | dec.st_ind | is_link);
   assign dm_waddr    = dec.st_ind ? ind_addr : dir_addr;
   assign dm_wdata    = is_link ? WORD_W'(pc_q + IA_W'(1)) : acc_q;

   acc16_ram #(.WIDTH(WORD_W), .DEPTH(DMEM_DEPTH), .NRD(2)) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_waddr),
      .wdata (dm_wdata),
      .raddr (dm_raddr),
      .rdata (dm_rdata)
   );

   // operand and ALU
   logic [WORD_W-1:0] opnd;
   logic [WORD_W-1:0] alu_res;
   assign opnd = dec.use_imm ? {{(WORD_W-8){fld[7]}}, fld} : dm_rdata[0];

   acc16_alu u_alu (
      .op   (dec.alu),
      .acc  (acc_q),
      .opnd (opnd),
      .res  (alu_res)
   );

   // delayed accumulator copies for branch conditions
   logic [COND_LAG:0][WORD_W-1:0] hist;
   assign hist[0] = acc_q;
   for (genvar s = 0; s < COND_LAG; s++) begin : g_hist
      always_ff @(posedge clk) begin
         if (rst) hist[s+1] <= '0;
         else     hist[s+1] <= hist[s];
      end
   end

   logic [IA_W-1:0] next_pc;
   acc16_branch #(.PC_W(IA_W)) u_br (
      .br       (dec.br),
      .pc       (pc_q),
      .offset   (fld),
      .cond_acc (hist[COND_LAG]),
      .next_pc  (next_pc)
   );

   // next accumulator and address register
   logic [WORD_W-1:0] acc_d;
   logic [WORD_W-1:0] ar_d;

   always_comb begin
      case (dec.sel)
         ACC_ALU: acc_d = alu_res;
         ACC_IO:  acc_d = io_rdata;
         ACC_IND: acc_d = dm_rdata[1];
         default: acc_d = acc_q;
      endcase
   end

   assign ar_d = (dm_we && dm_waddr == dir_addr) ? dm_wdata : dm_rdata[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q      <= IA_W'(1);
         acc_q     <= '0;
         ar_q      <= '0;
         illegal_q <= 1'b0;
      end else begin
         pc_q      <= next_pc;
         acc_q     <= acc_d;
         ar_q      <= ar_d;
         illegal_q <= illegal_q | dec.illegal;
      end
   end

   assign io_addr   = fld;
   assign io_wdata  = acc_q;
   assign io_wr     = ~rst & dec.io_out;
   assign io_rd     = ~rst & dec.io_in;
   assign illegal_o = illegal_q;

endmodule

// File: rtl/acc16_core_chk.sv
module acc16_core_chk #(
   parameter int unsigned IA_W = 10
) (
   input logic            clk,
   input logic            rst,
   input logic [IA_W-1:0] pc_q,
   input logic [15:0]     acc_q,
   input logic [15:0]     instr,
   input logic            io_wr,
   input logic            io_rd,
   input logic [15:0]     io_rdata,
   input logic            illegal_o
);

   logic [15:0] off16;
   assign off16 = {{8{instr[7]}}, instr[7:0]};

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (pc_q == IA_W'(1) && acc_q == 16'h0 && !illegal_o));

   a_r1_quiet_in_reset: assert property (@(posedge clk)
      rst |-> (!io_wr && !io_rd));

   a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(io_wr && io_rd));

   a_r6_in_captures: assert property (@(posedge clk) disable iff (rst)
      io_rd |=> acc_q == $past(io_rdata));

   a_r3_nop_keeps_acc: assert property (@(posedge clk) disable iff (rst)
      (instr[15:9] == 7'h00) |=> $stable(acc_q));

   a_r7_lda_keeps_acc: assert property (@(posedge clk) disable iff (rst)
      (instr[15:9] == 7'h28) |=> $stable(acc_q));

   a_r8_always_target: assert property (@(posedge clk) disable iff (rst)
      (instr[15:8] == 8'h48) |=> pc_q == $past(pc_q + off16[IA_W-1:0]));

   a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      illegal_o |=> illegal_o);

endmodule

bind acc16_core acc16_core_chk #(.IA_W(IA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .pc_q      (pc_q),
   .acc_q     (acc_q),
   .instr     (instr),
   .io_wr     (io_wr),
   .io_rd     (io_rd),
   .io_rdata  (io_rdata),
   .illegal_o (illegal_o)
);

// File: tb/acc16_core_tb.sv
module acc16_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        imem_we = 1'b0;
   logic [9:0]  imem_waddr = '0;
   logic [15:0] imem_wdata = '0;
   logic [7:0]  io_addr;
   logic [15:0] io_wdata;
   logic        io_wr;
   logic        io_rd;
   logic [15:0] io_rdata;
   logic        illegal_o;

   always #10 clk = ~clk;

   assign io_rdata = 16'hA500 ^ {8'h00, io_addr};

   acc16_core u_dut (
      .clk        (clk),
      .rst        (rst),
      .imem_we    (imem_we),
      .imem_waddr (imem_waddr),
      .imem_wdata (imem_wdata),
      .io_addr    (io_addr),
      .io_wdata   (io_wdata),
      .io_wr      (io_wr),
      .io_rd      (io_rd),
      .io_rdata   (io_rdata),
      .illegal_o  (illegal_o)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [23:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] prog [64];

   task automatic check(input bit ok, input string tag,
                        input logic [23:0] act, input logic [23:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_out(input logic [7:0] a, input logic [15:0] d, input string tag);
      exp_q.push_back({a, d});
      tag_q.push_back(tag);
   endtask

   // monitor: every device write must match the head of the queue
   always @(negedge clk) begin
      if (!rst && io_wr) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected device write", {io_addr, io_wdata}, 24'h0);
         end else begin
            logic [23:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({io_addr, io_wdata} === e, t, {io_addr, io_wdata}, e);
         end
      end
   end

   task automatic run_prog(input int cycles, input bit exp_illegal, input string tag);
      rst = 1'b1;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         imem_we    = 1'b1;
         imem_waddr = 10'(i);
         imem_wdata = prog[i];
      end
      @(negedge clk);
      imem_we = 1'b0;
      @(negedge clk);
      check(!io_wr && !io_rd && !illegal_o, "R1 quiet reset",
            {21'h0, io_wr, io_rd, illegal_o}, 24'h0);
      rst = 1'b0;
      repeat (cycles) @(negedge clk);
      check(exp_q.size() == 0, {tag, " all outputs seen"}, 24'(exp_q.size()), 24'h0);
      check(illegal_o == exp_illegal, "R10 illegal flag", {23'h0, illegal_o},
            {23'h0, exp_illegal});
      exp_q.delete();
      tag_q.delete();
   endtask

   initial begin
      // program A: operands, ALU, load-high, store
      foreach (prog[i]) prog[i] = 16'h0000;
      prog[0]  = 16'h38EE;
      prog[1]  = 16'h2105; prog[2]  = 16'h09FD; prog[3]  = 16'h3801;
      prog[4]  = 16'h300A; prog[5]  = 16'h2180; prog[6]  = 16'h3802;
      prog[7]  = 16'h080A; prog[8]  = 16'h3803; prog[9]  = 16'h2101;
      prog[10] = 16'h0D02; prog[11] = 16'h3804; prog[12] = 16'h1000;
      prog[13] = 16'h3805; prog[14] = 16'h230F; prog[15] = 16'h2570;
      prog[16] = 16'h270C; prog[17] = 16'h3806; prog[18] = 16'h2912;
      prog[19] = 16'h3807; prog[20] = 16'h2980; prog[21] = 16'h3808;
      prog[22] = 16'h4800;
      expect_out(8'h01, 16'h0002, "R3 add negative immediate");
      expect_out(8'h02, 16'hFF80, "R2 sign-extended immediate");
      expect_out(8'h03, 16'hFF82, "R5 R2 direct operand after store");
      expect_out(8'h04, 16'hFFFF, "R3 subtract wraps");
      expect_out(8'h05, 16'h7FFF, "R3 logical shift right");
      expect_out(8'h06, 16'h0073, "R3 and/or/xor");
      expect_out(8'h07, 16'h1273, "R4 load-high");
      expect_out(8'h08, 16'h8073, "R4 load-high negative");
      run_prog(60, 1'b0, "R1 program A");

      // program B: indirect, forwarding, IO input, illegal, jump-and-link
      foreach (prog[i]) prog[i] = 16'h0000;
      prog[0]  = 16'h38EE;
      prog[1]  = 16'h2144; prog[2]  = 16'h3008; prog[3]  = 16'h2103;
      prog[4]  = 16'h3014; prog[5]  = 16'h6005; prog[6]  = 16'h3801;
      prog[7]  = 16'h0901; prog[8]  = 16'h0014; prog[9]  = 16'h7009;
      prog[10] = 16'h2100; prog[11] = 16'h080C; prog[12] = 16'h3802;
      prog[13] = 16'h5014; prog[14] = 16'h3803; prog[15] = 16'h3C07;
      prog[16] = 16'h3804; prog[17] = 16'h1800; prog[18] = 16'h3805;
      prog[19] = 16'h211E; prog[20] = 16'h0000; prog[21] = 16'h4028;
      prog[22] = 16'h38EE; prog[30] = 16'h2028; prog[31] = 16'h3806;
      prog[32] = 16'h4800;
      expect_out(8'h01, 16'h0044, "R7 indirect load via forwarded reload");
      expect_out(8'h02, 16'h0045, "R7 indirect store");
      expect_out(8'h03, 16'h0045, "R7 load-address keeps accumulator");
      expect_out(8'h04, 16'hA507, "R6 input strobe and data");
      expect_out(8'h05, 16'hA507, "R10 illegal acts as no-op");
      expect_out(8'h06, 16'h0016, "R9 link word and delayed target");
      run_prog(80, 1'b1, "R7 program B");

      // program C: branches on the delayed accumulator
      foreach (prog[i]) prog[i] = 16'h0000;
      prog[0]  = 16'h38EE;
      prog[1]  = 16'h2100; prog[2]  = 16'h2105; prog[3]  = 16'h4903;
      prog[4]  = 16'h38E1; prog[5]  = 16'h38E2; prog[6]  = 16'h3801;
      prog[7]  = 16'h2180; prog[8]  = 16'h0000; prog[9]  = 16'h4C03;
      prog[10] = 16'h38E3; prog[11] = 16'h38E4; prog[12] = 16'h3802;
      prog[13] = 16'h2101; prog[14] = 16'h2100; prog[15] = 16'h4A03;
      prog[16] = 16'h38E5; prog[17] = 16'h38E6; prog[18] = 16'h3803;
      prog[19] = 16'h2100; prog[20] = 16'h0000; prog[21] = 16'h4A03;
      prog[22] = 16'h3804; prog[23] = 16'h2107; prog[24] = 16'h0000;
      prog[25] = 16'h4B03; prog[26] = 16'h38E7; prog[27] = 16'h38E8;
      prog[28] = 16'h3805; prog[29] = 16'h2180; prog[30] = 16'h0000;
      prog[31] = 16'h4BFE; prog[32] = 16'h3806; prog[33] = 16'h4803;
      prog[34] = 16'h3807; prog[35] = 16'h4800; prog[36] = 16'h48FE;
      expect_out(8'h01, 16'h0005, "R8 zero test uses delayed value");
      expect_out(8'h02, 16'hFF80, "R8 negative taken");
      expect_out(8'h03, 16'h0000, "R8 nonzero uses delayed value");
      expect_out(8'h04, 16'h0000, "R8 nonzero not taken");
      expect_out(8'h05, 16'h0007, "R8 positive taken");
      expect_out(8'h06, 16'hFF80, "R8 positive not taken");
      expect_out(8'h07, 16'hFF80, "R8 backward unconditional");
      run_prog(80, 1'b0, "R8 program C");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule